// File: doc/BRIEF.md
# Parallel Printer Port Register File

This block is the bus-side register set of a classic host parallel port. A small slave interface (2-bit offset, read strobe, write strobe, 8-bit write and read data) reaches three registers: a data latch at offset 0, a read-only status view at offset 1 and a control register at offset 2. The pin side has an eight-bit data bus that can be turned around, five status inputs, and four open-drain control lines whose real levels are read back.

The block applies the fixed polarity conventions of the port. The busy input reads inverted. Three of the four control lines are inverted at the pin. Control bit 5 turns the data pins around so that their levels can be read. Control bit 4 arms an interrupt that fires on a low-to-high change of the acknowledge input. Every pin input passes through a synchronizer before it is read or edge-detected.

The interrupt flag is held in a three-state machine. IRQ_IDLE (interrupt disabled) moves to IRQ_ARMED when the enable bit is set, or straight to IRQ_PEND if an acknowledge rise arrives in that same cycle. IRQ_ARMED moves to IRQ_PEND on an acknowledge rise and back to IRQ_IDLE when the enable is cleared. IRQ_PEND moves to IRQ_ARMED on a status read that is not accompanied by a new rise, and to IRQ_IDLE when the enable is cleared.

Top module: `ppt_regfile`

## Requirements
- R1: After reset the data latch and control register are 0, so `dat_pin_oe`=1, `dat_pin_o`=0x00, `ctl_pull_lo`=4'b0100 (only the initialize line pulled low), `irq`=0, and a control read returns 0x00 with the lines otherwise released.
- R2: A write to offset 0 stores the byte in the data latch, and `dat_pin_o` shows it after the write edge. While control bit 5 is 0, `dat_pin_oe`=1 and a read of offset 0 returns the latch.
- R3: While control bit 5 is 1, `dat_pin_oe`=0 and a read of offset 0 returns the synchronized data pins. Writes to offset 0 still update the latch, and the latch reads back again once bit 5 returns to 0.
- R4: A read of offset 1 returns {~busy, ack_n, paper, select, err_n, ~flag, 1, 1} (bit 7 down to bit 0) from synchronized pins. Bit 2 is 1 while no interrupt is pending.
- R5: Writes to offset 1 and to offset 3 change no state. A read of offset 3 returns 0x00.
- R6: A write to offset 2 stores bits 5:0 and drops bits 7:6. A read returns 0 in bits 7:6 and the stored values in bits 5:4.
- R7: The control lines are driven low as `ctl_pull_lo` = {c3, ~c2, c1, c0}, where bit 0 is strobe, bit 1 is auto linefeed, bit 2 is initialize and bit 3 is select printer. Writing xxxx0100 releases all four lines.
- R8: Control read bits 3:0 come from the synchronized line levels p: {~p3, p2, ~p1, ~p0}. A line pulled low from outside is therefore visible.
- R9: Each pin input passes through a two-stage synchronizer. A pin change made between two edges is first visible in a read after the second following edge.
- R10: With control bit 4 set, a low-to-high change of the synchronized ack_n sets the flag. `irq` equals the flag. A falling change does not set it.
- R11: A read of offset 1 while the flag is set clears it at that edge, unless a new acknowledge rise is seen in the same cycle.
- R12: Clearing control bit 4 clears the flag, and acknowledge rises while bit 4 is 0 are not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe (used to clear the interrupt on a status read) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| dat_pin_i | input | 8 | Data pin levels |
| dat_pin_o | output | 8 | Data latch value to drive onto the pins |
| dat_pin_oe | output | 1 | Data pin drive enable |
| stat_busy_i | input | 1 | Busy status pin |
| stat_ack_n_i | input | 1 | Acknowledge status pin, active low |
| stat_paper_i | input | 1 | Paper-out status pin |
| stat_sel_i | input | 1 | Select status pin |
| stat_err_n_i | input | 1 | Error status pin, active low |
| ctl_pin_i | input | 4 | Control line levels |
| ctl_pull_lo | output | 4 | Open-drain pull-down enable per control line |
| irq | output | 1 | Interrupt level |

## Verification
The bench goes after the line polarities. A swapped inversion on initialize or on busy would show the wrong level on a pin, or the wrong bit in a readback. It also checks turn-around: with the direction bit set, the design must not drive the pins, must return the pin levels, and must still update the latch. Otherwise the latch is lost, or the pins fight an outside driver. It exercises the synchronizer latency and the interrupt life cycle: falling acknowledge edges, clearing by a status read, and edges that arrive while disabled. A design that triggered on the wrong edge, missed the clear, or remembered disabled edges would raise `irq` where the model does not.

// File: rtl/ppt_pkg.sv
`timescale 1ns/1ps
package ppt_pkg;
    localparam int REG_W = 8;
    localparam int CTL_W = 4;
    localparam int STS_W = 5;

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    localparam int CB_IRQ_EN = 4;
    localparam int CB_DIR    = 5;
    localparam int CTRL_W    = 6;

    // control lines that are not inverted between register and pin
    localparam logic [CTL_W-1:0] CTL_TRUE_POL = 4'b0100;
    // status byte bits inverted between pin and register
    localparam logic [REG_W-1:0] STS_INV      = 8'b1000_0000;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_ARMED = 2'd1,
        IRQ_PEND  = 2'd2
    } irq_state_t;
endpackage

// File: rtl/ppt_sync.sv
`timescale 1ns/1ps
module ppt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ppt_irq_fsm.sv
`timescale 1ns/1ps
module ppt_irq_fsm import ppt_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack_rise,
    input  logic status_rd,
    output logic pending
);
    irq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE: begin
                if (enable && ack_rise) state_nx = IRQ_PEND;
                else if (enable)        state_nx = IRQ_ARMED;
            end
            IRQ_ARMED: begin
                if (!enable)       state_nx = IRQ_IDLE;
                else if (ack_rise) state_nx = IRQ_PEND;
            end
            IRQ_PEND: begin
                if (!enable)                     state_nx = IRQ_IDLE;
                else if (status_rd && !ack_rise) state_nx = IRQ_ARMED;
            end
            default: state_nx = IRQ_IDLE;
        endcase
    end

    always_comb begin
        pending = (state == IRQ_PEND);
    end
endmodule

// File: rtl/ppt_regfile.sv
`timescale 1ns/1ps
module ppt_regfile import ppt_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [REG_W-1:0] dat_pin_i,
    output logic [REG_W-1:0] dat_pin_o,
    output logic             dat_pin_oe,
    input  logic             stat_busy_i,
    input  logic             stat_ack_n_i,
    input  logic             stat_paper_i,
    input  logic             stat_sel_i,
    input  logic             stat_err_n_i,
    input  logic [CTL_W-1:0] ctl_pin_i,
    output logic [CTL_W-1:0] ctl_pull_lo,
    output logic             irq
);
    logic [REG_W-1:0]  data_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [REG_W-1:0]  dat_s;
    logic [STS_W-1:0]  sts_s;
    logic [CTL_W-1:0]  ctl_s;
    logic              ack_prev;
    logic              ack_rise;
    logic              status_rd;
    logic              pending;
    logic [REG_W-1:0]  sts_byte;
    logic [REG_W-1:0]  ctl_byte;

    ppt_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(dat_pin_i), .q(dat_s)
    );

    ppt_sync #(.WIDTH(STS_W), .STAGES(SYNC_STAGES)) u_sync_sts (
        .clk(clk), .rst_n(rst_n),
        .d({stat_busy_i, stat_ack_n_i, stat_paper_i, stat_sel_i, stat_err_n_i}),
        .q(sts_s)
    );

    ppt_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d(ctl_pin_i), .q(ctl_s)
    );

    // register writes; status offset and offset 3 hold no state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_DATA) data_q <= bus_wdata;
            if (bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    // acknowledge edge detection on the synchronized level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_prev <= 1'b0;
        else        ack_prev <= sts_s[3];
    end

    assign ack_rise  = sts_s[3] & ~ack_prev;
    assign status_rd = bus_rd && (bus_addr == OFS_STAT);

    ppt_irq_fsm u_irq (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl_q[CB_IRQ_EN]),
        .ack_rise(ack_rise),
        .status_rd(status_rd),
        .pending(pending)
    );

    assign irq         = pending;
    assign dat_pin_o   = data_q;
    assign dat_pin_oe  = ~ctrl_q[CB_DIR];
    assign ctl_pull_lo = ctrl_q[CTL_W-1:0] ^ CTL_TRUE_POL;

    assign sts_byte = {sts_s, ~pending, 2'b11} ^ STS_INV;
    assign ctl_byte = {2'b00, ctrl_q[CB_DIR:CB_IRQ_EN], ctl_s ^ ~CTL_TRUE_POL};

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = ctrl_q[CB_DIR] ? dat_s : data_q;
            OFS_STAT: bus_rdata = sts_byte;
            OFS_CTRL: bus_rdata = ctl_byte;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppt_regfile_chk.sv
`timescale 1ns/1ps
module ppt_regfile_chk import ppt_pkg::*; (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic [REG_W-1:0] dat_pin_o,
    input logic             dat_pin_oe,
    input logic [CTL_W-1:0] ctl_pull_lo,
    input logic             irq,
    input logic             ack_rise
);
    assert_data_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DATA) |=> dat_pin_o == $past(bus_wdata));

    assert_dir_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=> dat_pin_oe == !$past(bus_wdata[5]));

    assert_stat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_STAT) |-> (bus_rdata[1:0] == 2'b11 && bus_rdata[2] == !irq));

    assert_ctl_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_CTRL) |-> bus_rdata[7:6] == 2'b00);

    assert_pull_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=>
        ctl_pull_lo == {$past(bus_wdata[3]), !$past(bus_wdata[2]), $past(bus_wdata[1:0])});

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ack_rise));

    assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && bus_rd && bus_addr == OFS_STAT && !ack_rise) |=> !irq);

    assert_irq_disable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && !bus_wdata[4]) |=> ##1 !irq);
endmodule

bind ppt_regfile ppt_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dat_pin_o(dat_pin_o), .dat_pin_oe(dat_pin_oe),
    .ctl_pull_lo(ctl_pull_lo), .irq(irq), .ack_rise(ack_rise)
);

// File: tb/ppt_regfile_bench.sv
`timescale 1ns/1ps
module ppt_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] dat_pin, dat_o, dat_ext = 8'h5A;
    logic       dat_oe;
    logic       busy = 1'b0, ack_n = 1'b1, paper = 1'b0, sel = 1'b1, err_n = 1'b1;
    logic [3:0] ctl_pin, pull_lo, ctl_ext = 4'h0;
    logic       irq;

    integer n_chk = 0, n_bad = 0;
    logic   run_cmp = 1'b0, finished = 1'b0;

    always #4 clk = ~clk;

    assign dat_pin = dat_oe ? dat_o : dat_ext;
    assign ctl_pin = ~(pull_lo | ctl_ext);

    ppt_regfile u_ppt_regfile (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dat_pin_i(dat_pin), .dat_pin_o(dat_o), .dat_pin_oe(dat_oe),
        .stat_busy_i(busy), .stat_ack_n_i(ack_n), .stat_paper_i(paper),
        .stat_sel_i(sel), .stat_err_n_i(err_n),
        .ctl_pin_i(ctl_pin), .ctl_pull_lo(pull_lo), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    // snapshot: [16] busy [15] ack_n [14] paper [13] sel [12] err_n [11:4] data [3:0] ctl
    logic [16:0] hist[$];
    logic [7:0]  m_data;
    logic [5:0]  m_ctrl;
    logic        m_pend, m_prev;
    logic [16:0] m_snap, m_sv;
    logic        m_rise;
    logic [3:0]  m_pull;

    initial begin
        hist = '{17'h0, 17'h0};
        m_data = 0; m_ctrl = 0; m_pend = 0; m_prev = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_ctrl = 0; m_pend = 0; m_prev = 0;
            hist = '{17'h0, 17'h0};
        end else begin
            m_sv   = hist[1];
            m_rise = m_sv[15] && !m_prev;
            m_pull = {m_ctrl[3], ~m_ctrl[2], m_ctrl[1:0]};
            m_snap = {busy, ack_n, paper, sel, err_n,
                      (m_ctrl[5] ? dat_ext : m_data), ~(m_pull | ctl_ext)};
            m_pend = m_ctrl[4] && (m_rise || (m_pend && !(bus_rd && bus_addr == 2'd1)));
            if (bus_wr && bus_addr == 2'd0) m_data = bus_wdata;
            if (bus_wr && bus_addr == 2'd2) m_ctrl = bus_wdata[5:0];
            m_prev = m_sv[15];
            hist.push_front(m_snap);
            void'(hist.pop_back());
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        logic [16:0] s;
        s = hist[1];
        case (a)
            2'd0:    return m_ctrl[5] ? s[11:4] : m_data;
            2'd1:    return {~s[16], s[15], s[14], s[13], s[12], ~m_pend, 2'b11};
            2'd2:    return {2'b00, m_ctrl[5:4], ~s[3], s[2], ~s[1], ~s[0]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string lbl, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", lbl, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && run_cmp && !finished) begin
            chk("R2 dat_pin_o", dat_o, m_data);
            chk("R3 dat_pin_oe", {7'd0, dat_oe}, {7'd0, ~m_ctrl[5]});
            chk("R7 ctl_pull_lo", {4'd0, pull_lo}, {4'd0, m_ctrl[3], ~m_ctrl[2], m_ctrl[1:0]});
            chk("R10 irq level", {7'd0, irq}, {7'd0, m_pend});
            case (bus_addr)
                2'd0: chk("R3 data read", bus_rdata, exp_rd(2'd0));
                2'd1: chk("R4 status read", bus_rdata, exp_rd(2'd1));
                2'd2: chk("R8 control read", bus_rdata, exp_rd(2'd2));
                default: chk("R5 hole read", bus_rdata, exp_rd(2'd3));
            endcase
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #2 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [7:0] rv;

    initial begin
        wait_cyc(3);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(3);
        run_cmp = 1'b1;

        // R1 reset state
        chk("R1 pull after reset", {4'd0, pull_lo}, 8'h04);
        chk("R1 oe after reset", {7'd0, dat_oe}, 8'h01);
        chk("R1 data out after reset", dat_o, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        do_rd(2'd2, rv); chk("R1 control read after reset", rv, 8'h00);

        // R2 data latch
        do_wr(2'd0, 8'hA5);
        do_rd(2'd0, rv); chk("R2 data readback", rv, 8'hA5);
        chk("R2 data driven", dat_o, 8'hA5);

        // R4 status layout
        do_rd(2'd1, rv); chk("R4 status idle", rv, 8'hDF);

        // R5 ignored writes
        do_wr(2'd1, 8'h00);
        do_rd(2'd1, rv); chk("R5 status after write", rv, 8'hDF);
        do_wr(2'd3, 8'h77);
        do_rd(2'd3, rv); chk("R5 offset3 read", rv, 8'h00);
        do_rd(2'd0, rv); chk("R5 data untouched", rv, 8'hA5);

        // R9 synchronizer latency on busy
        @(negedge clk) busy = 1'b1;
        do_rd(2'd1, rv); chk("R9 busy after one edge", rv, 8'hDF);
        do_rd(2'd1, rv); chk("R9 busy after two edges", rv, 8'h5F);

        // R6, R7, R8 control register and lines
        do_wr(2'd2, 8'hC1);
        chk("R7 pull strobe", {4'd0, pull_lo}, 8'h05);
        wait_cyc(3);
        do_rd(2'd2, rv); chk("R6 upper bits dropped", rv, 8'h01);
        ctl_ext = 4'b1000;
        wait_cyc(3);
        do_rd(2'd2, rv); chk("R8 external pull seen", rv, 8'h09);
        do_wr(2'd2, 8'h04);
        chk("R7 all released", {4'd0, pull_lo}, 8'h00);
        wait_cyc(3);
        do_rd(2'd2, rv); chk("R8 released readback", rv, 8'h0C);
        ctl_ext = 4'b0000;

        // R3 direction
        do_wr(2'd2, 8'h20);
        wait_cyc(3);
        chk("R3 oe off", {7'd0, dat_oe}, 8'h00);
        do_rd(2'd0, rv); chk("R3 pin readback", rv, 8'h5A);
        do_wr(2'd0, 8'h3C);
        do_rd(2'd0, rv); chk("R3 read still pins", rv, 8'h5A);
        chk("R3 latch updated", dat_o, 8'h3C);
        do_rd(2'd2, rv); chk("R6 direction bit reads", rv[5:4], 8'h02);
        do_wr(2'd2, 8'h04);
        do_rd(2'd0, rv); chk("R3 latch back", rv, 8'h3C);

        // R10 interrupt on rising ack
        do_wr(2'd2, 8'h14);
        @(negedge clk) ack_n = 1'b0;
        wait_cyc(4); chk("R10 falling edge ignored", {7'd0, irq}, 8'h00);
        ack_n = 1'b1;
        wait_cyc(4); chk("R10 rising edge raises", {7'd0, irq}, 8'h01);
        do_rd(2'd1, rv); chk("R10 status flag bit", rv, 8'h5B);
        @(negedge clk); chk("R11 cleared by status read", {7'd0, irq}, 8'h00);
        do_rd(2'd1, rv); chk("R11 status after clear", rv, 8'h5F);

        // R12 disable clears and blocks
        ack_n = 1'b0; wait_cyc(4);
        ack_n = 1'b1; wait_cyc(4);
        chk("R10 second event", {7'd0, irq}, 8'h01);
        do_wr(2'd2, 8'h04);
        wait_cyc(2); chk("R12 disable clears", {7'd0, irq}, 8'h00);
        ack_n = 1'b0; wait_cyc(4);
        ack_n = 1'b1; wait_cyc(4);
        chk("R12 edge while disabled", {7'd0, irq}, 8'h00);
        do_wr(2'd2, 8'h14);
        wait_cyc(3); chk("R12 not remembered", {7'd0, irq}, 8'h00);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_addr  = 2'($urandom);
            bus_rd    = ($urandom % 3) == 0;
            bus_wr    = !bus_rd && (($urandom % 4) == 0);
            bus_wdata = 8'($urandom);
            if (($urandom % 5) == 0) ack_n = ~ack_n;
            if (($urandom % 9) == 0) busy = ~busy;
            if (($urandom % 11) == 0) {paper, sel, err_n} = 3'($urandom);
            if (($urandom % 7) == 0) dat_ext = 8'($urandom);
            if (($urandom % 13) == 0) ctl_ext = 4'($urandom);
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        wait_cyc(2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule